// File: doc/BRIEF.md
# Bit-Serial Binary-Field Polynomial Multiplier

This block computes the product of two elements of the binary extension field GF(2^m) in polynomial basis. Bit i of an operand is the coefficient of x^i. The product is reduced by a field polynomial that arrives on an input port at run time, so one instance can serve several curves or fields of the same degree. Addition in the field is bitwise XOR and never produces a carry. The datapath takes one bit of the multiplier operand per clock, starting at its most significant bit. In the same clock it folds the partial product back into m bits.

A one-cycle `start` pulse latches both operands and the field polynomial and clears the accumulator. The controller has two states. IDLE moves to RUN when `start` is seen, and that edge does the capture. RUN stays in RUN while bits of the multiplier remain. RUN returns to IDLE on the edge that consumes the last bit, and `done` rises on that same edge. A full multiply takes m+1 clocks including the start cycle. `busy` is high for the m cycles in RUN. `result` keeps its value until the next accepted start.

Top module: `gf_mul_serial`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is all zeros.
- R2: With `poly[M]` set, `result` equals the carry-free (XOR) product of `a` and `b` reduced modulo `poly`, where bit i of every vector is the coefficient of x^i.
- R3: `done` goes high exactly M clocks after the edge that accepts `start`, so a multiply takes M+1 clocks including the start cycle.
- R4: `busy` is high on every cycle from the accepting edge until `done` rises, and it is low while `done` is high.
- R5: `done` stays high for exactly one cycle per multiply.
- R6: The reduction follows the `poly` value captured at run time: the same operands with a different polynomial give the product reduced by that polynomial.
- R7: When `poly[M]` (the leading term) is clear, no reduction takes place and `result` is the product truncated to its M low coefficients.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running multiply finishes on time with its original operands.
- R9: Changing `a`, `b` or `poly` after the accepting edge has no effect on the multiply in progress. `result` holds its value from `done` until the next accepted start.
- R10: The default parameter M = 128 is supported. As an example, x^127 times x modulo x^128 + x^7 + x^2 + x + 1 gives 0x87.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; accepted only in IDLE |
| a | input | M | Multiplicand, coefficient i at bit i |
| b | input | M | Multiplier, consumed most significant bit first |
| poly | input | M+1 | Field polynomial including the x^M term at bit M |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse when `result` becomes valid |
| result | output | M | Reduced product |

## Verification
The multiply is tried with several operand pairs, each chosen to expose a different fault:
- An identity multiplier and a zero multiplier show whether the bit order of the multiplier is scanned correctly and whether the accumulator is cleared.
- The single-term case x^127 · x isolates one reduction step.
- Dense all-ones and alternating-bit operands force a reduction on nearly every iteration and expose a missing or misplaced XOR.
- Swapping the operands, changing the polynomial, and clearing its leading term tell apart a fixed-polynomial or asymmetric datapath from a correct one.
- Changes to the inputs in mid-run and a stray start request show whether the operands are really captured and starts are really ignored while busy.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gf_state_e;
endpackage

// File: rtl/gf_mul_step.sv
module gf_mul_step #(
    parameter int M = 128
) (
    input  logic [M-1:0] acc,
    input  logic [M-1:0] a,
    input  logic [M:0]   poly,
    input  logic         b_bit,
    output logic [M-1:0] nxt
);
    // overflow term after the shift, folded only when the leading term is present
    logic fold;
    assign fold = acc[M-1] & poly[M];

    for (genvar i = 0; i < M; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt[i] = (b_bit & a[i]) ^ (fold & poly[i]);
        end else begin : g_upper
            assign nxt[i] = acc[i-1] ^ (b_bit & a[i]) ^ (fold & poly[i]);
        end
    end
endmodule

// File: rtl/gf_mul_ctrl.sv
module gf_mul_ctrl
    import gf_mul_pkg::*;
#(
    parameter int M = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = (M > 1) ? $clog2(M) : 1;

    gf_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            done_q, done_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    cnt_d   = CW'(M - 1);
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        busy = (state_q == ST_RUN);
        done = done_q;
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R3
    last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0) |=> (done && !busy));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (busy && !done));
endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
    parameter int M = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    input  logic [M:0]   poly,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] result
);
    logic         load, step;
    logic [M-1:0] a_q, b_q, c_q, c_nxt;
    logic [M:0]   p_q;

    gf_mul_ctrl #(.M(M)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    gf_mul_step #(.M(M)) u_step (
        .acc   (c_q),
        .a     (a_q),
        .poly  (p_q),
        .b_bit (b_q[M-1]),
        .nxt   (c_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            p_q <= '0;
            c_q <= '0;
        end else if (load) begin
            a_q <= a;
            b_q <= b;
            p_q <= poly;
            c_q <= '0;
        end else if (step) begin
            c_q <= c_nxt;
            b_q <= {b_q[M-2:0], 1'b0};
        end
    end

    assign result = c_q;

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
endmodule

// File: tb/tb_gf_mul_serial.sv
`timescale 1ns/1ps
module tb_gf_mul_serial;
    localparam int M = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_i = '0;
    logic [M-1:0] b_i = '0;
    logic [M:0]   p_i = '0;
    logic         busy, done;
    logic [M-1:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gf_mul_serial dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a(a_i), .b(b_i), .poly(p_i),
        .busy(busy), .done(done), .result(result)
    );

    localparam logic [M:0] POLY_A = {1'b1, 128'h87};
    localparam logic [M:0] POLY_B = {1'b1, 128'h4000_0000_0000_0000_0000_0000_0000_0003};

    // schoolbook carry-free product, then top-down reduction
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y,
                                             input logic [M:0] p);
        logic [2*M-2:0] prod;
        prod = '0;
        for (int i = 0; i < M; i++)
            if (y[i]) prod = prod ^ ({{(M-1){1'b0}}, x} << i);
        if (p[M]) begin
            for (int k = 2*M-2; k >= M; k--)
                if (prod[k]) prod = prod ^ ({{(M-2){1'b0}}, p} << (k - M));
        end
        return prod[M-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [M:0] act, input logic [M:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // mode 0: plain; 1: change inputs after capture; 2: stray start while busy
    task automatic do_mul(input logic [M-1:0] x, input logic [M-1:0] y, input logic [M:0] p,
                          input int mode, output logic [M-1:0] r);
        int cyc;
        int busy_bad;
        @(negedge clk);
        a_i = x; b_i = y; p_i = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        busy_bad = 0;
        while (!done && cyc < 4*M) begin
            if (!busy) busy_bad++;
            if (mode == 1 && cyc == 0) begin
                a_i = ~x; b_i = ~y; p_i = POLY_B ^ p;
            end
            if (mode == 2 && cyc == 2) begin
                a_i = x ^ 128'h1234; b_i = ~y; start = 1'b1;
            end
            if (mode == 2 && cyc == 3) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        // R3: M clocks after the accepting edge
        check(cyc == M, "R3 latency", (M+1)'(cyc), (M+1)'(M));
        // R4: busy through the run, low with done
        check(busy_bad == 0 && !busy, "R4 busy window", (M+1)'(busy_bad), '0);
        r = result;
        @(negedge clk);
        // R5: single-cycle done
        check(!done, "R5 done pulse", (M+1)'(done), '0);
    endtask

    task automatic t_reset();
        // R1
        check(!busy, "R1 busy after reset", (M+1)'(busy), '0);
        check(!done, "R1 done after reset", (M+1)'(done), '0);
        check(result == '0, "R1 result after reset", {1'b0, result}, '0);
    endtask

    task automatic t_special();
        logic [M-1:0] r;
        logic [M-1:0] av;
        av = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
        do_mul(av, 128'h1, POLY_A, 0, r);
        check(r == av, "R2 identity", {1'b0, r}, {1'b0, av});
        do_mul(av, '0, POLY_A, 0, r);
        check(r == '0, "R2 zero multiplier", {1'b0, r}, '0);
        do_mul({1'b1, 127'b0}, 128'h2, POLY_A, 0, r);
        check(r == 128'h87, "R10 x^127*x at M=128", {1'b0, r}, {1'b0, 128'h87});
    endtask

    task automatic t_patterns();
        logic [M-1:0] r, r2;
        logic [M-1:0] xs [4];
        logic [M-1:0] ys [4];
        xs[0] = '1;                                        ys[0] = '1;
        xs[1] = {64{2'b01}};                               ys[1] = {64{2'b10}};
        xs[2] = 128'h8000_0000_0000_0001_8000_0000_0000_0001; ys[2] = 128'hFFFF_0000_FFFF_0000_1234_5678_9ABC_DEF0;
        xs[3] = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0; ys[3] = 128'hC001_D00D_0BAD_F00D_1357_9BDF_2468_ACE0;
        for (int i = 0; i < 4; i++) begin
            do_mul(xs[i], ys[i], POLY_A, 0, r);
            check(r == ref_mul(xs[i], ys[i], POLY_A), "R2 pattern product", {1'b0, r},
                  {1'b0, ref_mul(xs[i], ys[i], POLY_A)});
        end
        do_mul(ys[3], xs[3], POLY_A, 0, r2);
        check(r2 == ref_mul(xs[3], ys[3], POLY_A), "R2 swapped operands", {1'b0, r2},
              {1'b0, ref_mul(xs[3], ys[3], POLY_A)});
    endtask

    task automatic t_poly();
        logic [M-1:0] r, x, y;
        x = 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF;
        y = 128'hF0F0_F0F0_0F0F_0F0F_AAAA_5555_3333_CCCC;
        do_mul(x, y, POLY_B, 0, r);
        check(r == ref_mul(x, y, POLY_B), "R6 runtime polynomial", {1'b0, r}, {1'b0, ref_mul(x, y, POLY_B)});
        check(r != ref_mul(x, y, POLY_A), "R6 polynomial matters", {1'b0, r}, {1'b0, ref_mul(x, y, POLY_A)});
        do_mul(x, y, {1'b0, POLY_A[M-1:0]}, 0, r);
        check(r == ref_mul(x, y, {1'b0, POLY_A[M-1:0]}), "R7 no leading term truncates", {1'b0, r},
              {1'b0, ref_mul(x, y, {1'b0, POLY_A[M-1:0]})});
    endtask

    task automatic t_capture();
        logic [M-1:0] r, x, y;
        x = 128'h1357_9BDF_0246_8ACE_FFFF_0000_1111_2222;
        y = 128'h8421_8421_8421_8421_7777_8888_9999_AAAA;
        do_mul(x, y, POLY_A, 1, r);
        check(r == ref_mul(x, y, POLY_A), "R9 inputs captured at start", {1'b0, r}, {1'b0, ref_mul(x, y, POLY_A)});
    endtask

    task automatic t_ignore_start();
        logic [M-1:0] r, x, y;
        x = 128'hA5A5_5A5A_C3C3_3C3C_9696_6969_F00F_0FF0;
        y = 128'h0000_0001_0000_0002_0000_0004_8000_0008;
        do_mul(x, y, POLY_B, 2, r);
        check(r == ref_mul(x, y, POLY_B), "R8 stray start ignored", {1'b0, r}, {1'b0, ref_mul(x, y, POLY_B)});
        check(!busy, "R8 no second run", (M+1)'(busy), '0);
    endtask

    task automatic t_hold();
        logic [M-1:0] r, x, y;
        int moved;
        x = 128'h0BAD_CAFE_1234_0000_FFFF_EEEE_DDDD_CCCC;
        y = 128'h7FFF_FFFF_FFFF_FFFF_0000_0000_0000_0001;
        do_mul(x, y, POLY_A, 0, r);
        moved = 0;
        for (int i = 0; i < 10; i++) begin
            a_i = ~a_i; b_i = b_i ^ 128'h5; p_i = POLY_B;
            @(negedge clk);
            if (result != r || busy) moved++;
        end
        check(moved == 0, "R9 result held after done", {1'b0, result}, {1'b0, r});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R3 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_special();
        t_patterns();
        t_poly();
        t_capture();
        t_ignore_start();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule